// File: doc/BRIEF.md
# Restartable Padded Byte-Move Engine

This block copies a run of bytes from one memory region to another over a byte-wide read/write port. Each region is given by a start address and a 24-bit byte count. When the source run is shorter than the destination run, the remaining destination bytes are filled with a pad value. The pad value travels in the top byte of the 32-bit source-count word. A pad of zero with an empty source therefore clears the destination.

The engine keeps four descriptor registers: destination address, destination count, source address and source count word. All four are visible on output ports and are updated after every byte. They therefore always describe exactly the work still outstanding. An interrupt request stops the move after the byte in flight. Feeding the four registers back into the load inputs on a later start resumes the move with no other saved state.

A copied byte takes two cycles: a source read, then a destination write of the returned byte. A padded byte takes one cycle: a single destination write.

Top module: `mvpad_engine`

## Requirements
- R1: After reset, busy, done and stopped are low and no memory access is issued. A start while idle loads all four descriptor registers from the load inputs. A start while busy is ignored.
- R2: While the source count is nonzero, each byte is moved in two cycles. The source read comes first; the write follows in the next cycle and carries the read data, which memory returns one cycle after the read. The write then raises both addresses by one and lowers both counts by one.
- R3: When the source count is zero and the destination count is not, each cycle writes the pad byte (bits 31:24 of the source-count word) to the destination address. The source address, the source count and the pad byte stay unchanged.
- R4: A source count of zero with a pad of zero clears every destination byte in the range.
- R5: A start with a destination count of zero sets done at the next clock edge, leaves busy low and issues no memory access.
- R6: The move ends with done when the destination count reaches zero. Any source bytes not needed remain in the source address and count.
- R7: An interrupt request is sampled only in a destination-write cycle. That write still completes, after which the engine goes idle with stopped high, done low, and registers that describe the remaining work.
- R8: An interrupt request during a source-read cycle, or while idle, has no effect.
- R9: Restarting with the four output registers fed back to the load inputs after a stop gives the same final memory contents as an uninterrupted move. This holds in the copy phase and in the pad phase.
- R10: If an interrupt request arrives in the cycle that writes the last destination byte, the move ends with done high and stopped low.
- R11: Addresses and counts need no alignment; odd start addresses and odd counts move correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load descriptors and begin (honoured only when idle) |
| irq | input | 1 | Interrupt request, sampled at byte boundaries |
| ld_dst_addr | input | AW | Destination address to load |
| ld_dst_cnt | input | CW | Destination byte count to load |
| ld_src_addr | input | AW | Source address to load |
| ld_src_cnt | input | PW+CW | Source count word to load: pad byte on top, count below |
| dst_addr | output | AW | Live destination address |
| dst_cnt | output | CW | Live destination count |
| src_addr | output | AW | Live source address |
| src_cnt | output | PW+CW | Live source count word including the pad byte |
| busy | output | 1 | A move is in progress |
| done | output | 1 | Last move finished (held until the next start) |
| stopped | output | 1 | Last move was interrupted (held until the next start) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | PW | Memory write data |
| mem_rdata | input | PW | Memory read data, valid the cycle after mem_rd |

## Verification
The two events that can land in the same cycle are the write of the final destination byte and an interrupt request. Either could claim the end state. The bench provokes the overlap by counting write strobes and raising the request exactly in the cycle of the last write. It expects done with stopped low and a fully written destination. It also raises the request on an earlier write and checks the stopped state and the remaining counts. A resume from those registers must then produce the same memory image as an uninterrupted run.

// File: rtl/mvp_pkg.sv
package mvp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WRITE = 2'd2
    } mvp_state_t;

    typedef struct packed {
        logic rd;
        logic wr;
        logic from_pad;
        logic step_src;
        logic step_dst;
    } mvp_ctl_t;

    function automatic logic cnt_is_one(input logic [31:0] c);
        return c == 32'd1;
    endfunction

endpackage

// File: rtl/mvp_operand.sv
module mvp_operand #(
    parameter int AW = 32,
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] ld_addr,
    input  logic [CW-1:0] ld_cnt,
    input  logic          step,
    output logic [AW-1:0] addr,
    output logic [CW-1:0] cnt,
    output logic          empty
);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr <= '0;
            cnt  <= '0;
        end else if (load) begin
            addr <= ld_addr;
            cnt  <= ld_cnt;
        end else if (step) begin
            addr <= addr + AW'(1);
            cnt  <= cnt - CW'(1);
        end
    end

    assign empty = (cnt == '0);

    // R2: a step only happens on a nonzero count
    a_r2_step_nonzero: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |-> !empty);

    // R2: a step advances the address and lowers the count by one
    a_r2_step_effect: assert property (@(posedge clk) disable iff (rst)
        (step && !load) |=> (cnt == $past(cnt) - CW'(1)) && (addr == $past(addr) + AW'(1)));

endmodule

// File: rtl/mvp_ctrl.sv
module mvp_ctrl #(
    parameter int CW = 24
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            irq,
    input  logic            ld_dst_zero,
    input  logic [CW-1:0]   dst_cnt,
    input  logic            src_empty,
    output mvp_pkg::mvp_ctl_t ctl,
    output logic            load,
    output logic            busy,
    output logic            done,
    output logic            stopped
);
    import mvp_pkg::*;

    mvp_state_t st, st_nxt;
    logic       set_done, set_stop;
    logic       last_byte;

    assign last_byte = cnt_is_one(32'(dst_cnt));

    always_comb begin
        ctl      = '0;
        load     = 1'b0;
        st_nxt   = st;
        set_done = 1'b0;
        set_stop = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (start) begin
                    load = 1'b1;
                    if (ld_dst_zero) set_done = 1'b1;
                    else             st_nxt   = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (!src_empty) begin
                    ctl.rd = 1'b1;
                    st_nxt = ST_WRITE;
                end else begin
                    ctl.wr       = 1'b1;
                    ctl.from_pad = 1'b1;
                    ctl.step_dst = 1'b1;
                end
            end
            ST_WRITE: begin
                ctl.wr       = 1'b1;
                ctl.step_src = 1'b1;
                ctl.step_dst = 1'b1;
            end
            default: st_nxt = ST_IDLE;
        endcase
        if (ctl.wr) begin
            if (last_byte) begin
                set_done = 1'b1;
                st_nxt   = ST_IDLE;
            end else if (irq) begin
                set_stop = 1'b1;
                st_nxt   = ST_IDLE;
            end else begin
                st_nxt   = ST_ISSUE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            done    <= 1'b0;
            stopped <= 1'b0;
        end else begin
            st <= st_nxt;
            if (load) begin
                done    <= set_done;
                stopped <= 1'b0;
            end else begin
                if (set_done) done    <= 1'b1;
                if (set_stop) stopped <= 1'b1;
            end
        end
    end

    assign busy = (st != ST_IDLE);

    // R7: the two end states never coexist
    a_r7_end_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(done && stopped));

    // R8: a read cycle always continues into its write, whatever irq does
    a_r8_read_continues: assert property (@(posedge clk) disable iff (rst)
        ctl.rd |=> (st == ST_WRITE));

    // R10: the final write wins over a coincident interrupt
    a_r10_done_over_irq: assert property (@(posedge clk) disable iff (rst)
        (ctl.wr && last_byte && irq) |=> (done && !stopped && !busy));

endmodule

// File: rtl/mvpad_engine.sv
module mvpad_engine #(
    parameter int AW = 32,
    parameter int CW = 24,
    parameter int PW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            irq,
    input  logic [AW-1:0]   ld_dst_addr,
    input  logic [CW-1:0]   ld_dst_cnt,
    input  logic [AW-1:0]   ld_src_addr,
    input  logic [PW+CW-1:0] ld_src_cnt,
    output logic [AW-1:0]   dst_addr,
    output logic [CW-1:0]   dst_cnt,
    output logic [AW-1:0]   src_addr,
    output logic [PW+CW-1:0] src_cnt,
    output logic            busy,
    output logic            done,
    output logic            stopped,
    output logic            mem_rd,
    output logic            mem_wr,
    output logic [AW-1:0]   mem_addr,
    output logic [PW-1:0]   mem_wdata,
    input  logic [PW-1:0]   mem_rdata
);
    import mvp_pkg::*;

    localparam int WW = PW + CW;

    mvp_ctl_t      ctl;
    logic          load;
    logic          src_empty, dst_empty;
    logic [CW-1:0] src_cnt_lo;
    logic [PW-1:0] pad_q;

    mvp_ctrl #(.CW(CW)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .irq         (irq),
        .ld_dst_zero (ld_dst_cnt == '0),
        .dst_cnt     (dst_cnt),
        .src_empty   (src_empty),
        .ctl         (ctl),
        .load        (load),
        .busy        (busy),
        .done        (done),
        .stopped     (stopped)
    );

    mvp_operand #(.AW(AW), .CW(CW)) u_dst (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .ld_addr (ld_dst_addr),
        .ld_cnt  (ld_dst_cnt),
        .step    (ctl.step_dst),
        .addr    (dst_addr),
        .cnt     (dst_cnt),
        .empty   (dst_empty)
    );

    mvp_operand #(.AW(AW), .CW(CW)) u_src (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .ld_addr (ld_src_addr),
        .ld_cnt  (ld_src_cnt[CW-1:0]),
        .step    (ctl.step_src),
        .addr    (src_addr),
        .cnt     (src_cnt_lo),
        .empty   (src_empty)
    );

    always_ff @(posedge clk) begin
        if (rst)       pad_q <= '0;
        else if (load) pad_q <= ld_src_cnt[WW-1:CW];
    end

    assign src_cnt   = {pad_q, src_cnt_lo};
    assign mem_rd    = ctl.rd;
    assign mem_wr    = ctl.wr;
    assign mem_addr  = ctl.rd ? src_addr : dst_addr;
    assign mem_wdata = ctl.from_pad ? pad_q : mem_rdata;

    // R1: one memory access per cycle at most
    a_r1_one_access: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R3: the source side is frozen while padding
    a_r3_src_frozen: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && src_empty) |=> ($stable(src_addr) && $stable(src_cnt)));

    // R5: an empty destination finishes at once
    a_r5_zero_dst: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && ld_dst_cnt == '0) |=> (done && !busy && !mem_rd && !mem_wr));

    // R6: done implies no destination bytes remain
    a_r6_done_empty: assert property (@(posedge clk) disable iff (rst)
        done |-> dst_empty);

endmodule

// File: tb/mvpad_engine_bench.sv
module mvpad_engine_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        irq = 1'b0;
    logic [31:0] ld_dst_addr = '0, ld_src_addr = '0;
    logic [23:0] ld_dst_cnt = '0;
    logic [31:0] ld_src_cnt = '0;
    logic [31:0] dst_addr, src_addr, mem_addr, src_cnt;
    logic [23:0] dst_cnt;
    logic        busy, done, stopped, mem_rd, mem_wr;
    logic [7:0]  mem_wdata, mem_rdata;

    int n_chk = 0;
    int n_fail = 0;
    int n_access = 0;
    int cyc = 0;

    logic [7:0] mem [0:255];
    logic       fill_req = 1'b0;
    int         fill_seed = 0;

    always #5 clk = ~clk;

    mvpad_engine u_mvpad_engine (
        .clk(clk), .rst(rst), .start(start), .irq(irq),
        .ld_dst_addr(ld_dst_addr), .ld_dst_cnt(ld_dst_cnt),
        .ld_src_addr(ld_src_addr), .ld_src_cnt(ld_src_cnt),
        .dst_addr(dst_addr), .dst_cnt(dst_cnt),
        .src_addr(src_addr), .src_cnt(src_cnt),
        .busy(busy), .done(done), .stopped(stopped),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] pat(int a, int seed);
        return 8'((a * 7 + seed * 13 + 3) & 255);
    endfunction

    always @(posedge clk) begin
        if (fill_req) begin
            for (int i = 0; i < 256; i++) mem[i] <= pat(i, fill_seed);
        end else begin
            if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
            if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
        end
        if (mem_rd || mem_wr) n_access++;
        cyc++;
    end

    initial begin
        wait (cyc > 100000);
        n_fail++;
        $display("FAIL watchdog: run did not end, got %0d cycles expected under 100000", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    task automatic check(string tag, longint act, longint exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic fill(int seed);
        @(negedge clk);
        fill_seed = seed;
        fill_req  = 1'b1;
        @(negedge clk);
        fill_req  = 1'b0;
    endtask

    task automatic launch(logic [31:0] da, logic [23:0] dc,
                          logic [31:0] sa, logic [31:0] sc);
        @(negedge clk);
        ld_dst_addr = da; ld_dst_cnt = dc;
        ld_src_addr = sa; ld_src_cnt = sc;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end(output int ncyc);
        ncyc = 0;
        while (!(done || stopped) && ncyc < 2000) begin
            @(negedge clk);
            ncyc++;
        end
    endtask

    task automatic check_image(string tag, int seed, int d, int dc, int s, int sc, int pad);
        int bad = 0;
        for (int a = 0; a < 256; a++) begin
            logic [7:0] e;
            e = pat(a, seed);
            if (a >= d && a < d + dc) e = (a - d < sc) ? pat(s + a - d, seed) : 8'(pad);
            if (mem[a] !== e) bad++;
        end
        check(tag, bad, 0);
    endtask

    task automatic pulse_irq_on_write(int k);
        int c = 0;
        while (1) begin
            if (mem_wr) c++;
            if (c == k) break;
            @(negedge clk);
        end
        irq = 1'b1;
        @(negedge clk);
        irq = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 reset busy", busy, 0);
        check("R1 reset done", done, 0);
        check("R1 reset stopped", stopped, 0);
        check("R1 reset access", n_access, 0);
    endtask

    task automatic t_copy;
        int n;
        fill(1);
        launch(32'h41, 24'd11, 32'h13, {8'hAA, 24'd20});
        check("R1 loaded dst_cnt", dst_cnt, 11);
        wait_end(n);
        check("R2 cycles two per byte", n, 22);
        check("R6 done", done, 1);
        check("R6 dst_cnt", dst_cnt, 0);
        check("R2 dst_addr", dst_addr, 32'h4C);
        check("R6 src remainder", src_cnt, {8'hAA, 24'd9});
        check("R2 src_addr", src_addr, 32'h1E);
        check_image("R11 odd copy image", 1, 'h41, 11, 'h13, 20, 'hAA);
    endtask

    task automatic t_pad;
        int n;
        fill(2);
        launch(32'h80, 24'd12, 32'h23, {8'h5C, 24'd5});
        wait_end(n);
        check("R3 cycles", n, 17);
        check("R3 src_addr frozen", src_addr, 32'h28);
        check("R3 src_cnt word", src_cnt, {8'h5C, 24'd0});
        check_image("R3 pad image", 2, 'h80, 12, 'h23, 5, 'h5C);
    endtask

    task automatic t_zero_fill;
        int n;
        fill(3);
        launch(32'h90, 24'd9, 32'h31, 32'h0);
        wait_end(n);
        check("R4 cycles", n, 9);
        check("R4 src_addr", src_addr, 32'h31);
        check_image("R4 zero image", 3, 'h90, 9, 'h31, 0, 0);
    endtask

    task automatic t_zero_dst;
        int a0;
        fill(4);
        a0 = n_access;
        launch(32'h50, 24'd0, 32'h10, {8'h77, 24'd6});
        check("R5 done at once", done, 1);
        check("R5 busy", busy, 0);
        repeat (3) @(negedge clk);
        check("R5 no access", n_access - a0, 0);
        check_image("R5 image", 4, 0, 0, 0, 0, 0);
    endtask

    task automatic t_busy_start;
        int n;
        fill(5);
        launch(32'h60, 24'd8, 32'h05, {8'h11, 24'd8});
        repeat (3) @(negedge clk);
        ld_dst_addr = 32'hC0; ld_dst_cnt = 24'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_end(n);
        check("R1 start while busy ignored dst_addr", dst_addr, 32'h68);
        check_image("R1 busy start image", 5, 'h60, 8, 'h05, 8, 'h11);
    endtask

    task automatic t_irq_resume(int sc, int k, string tg);
        int n;
        fill(6);
        launch(32'hA0, 24'd16, 32'h05, {8'h3D, 24'(sc)});
        pulse_irq_on_write(k);
        wait_end(n);
        check({tg, " R7 stopped"}, stopped, 1);
        check({tg, " R7 not done"}, done, 0);
        check({tg, " R7 dst_cnt remaining"}, dst_cnt, 16 - k);
        check({tg, " R7 dst_addr"}, dst_addr, 32'hA0 + k);
        check({tg, " R7 src_cnt"}, src_cnt[23:0], (k < sc) ? sc - k : 0);
        launch(dst_addr, dst_cnt, src_addr, src_cnt);
        wait_end(n);
        check({tg, " R9 resume done"}, done, 1);
        check_image({tg, " R9 resume image"}, 6, 'hA0, 16, 'h05, sc, 'h3D);
    endtask

    task automatic t_irq_read;
        int n;
        fill(7);
        @(negedge clk);
        irq = 1'b1;
        @(negedge clk);
        irq = 1'b0;
        check("R8 idle irq busy", busy, 0);
        check("R8 idle irq stopped", stopped, 0);
        launch(32'hB0, 24'd4, 32'h40, {8'h00, 24'd4});
        check("R8 read cycle", mem_rd, 1);
        irq = 1'b1;
        @(negedge clk);
        irq = 1'b0;
        wait_end(n);
        check("R8 read irq ignored done", done, 1);
        check("R8 read irq ignored stopped", stopped, 0);
        check_image("R8 image", 7, 'hB0, 4, 'h40, 4, 0);
    endtask

    task automatic t_collide;
        int n;
        fill(8);
        launch(32'hD0, 24'd4, 32'h21, {8'hEE, 24'd2});
        pulse_irq_on_write(4);
        wait_end(n);
        check("R10 done wins", done, 1);
        check("R10 not stopped", stopped, 0);
        check_image("R10 image", 8, 'hD0, 4, 'h21, 2, 'hEE);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_copy();
        t_pad();
        t_zero_fill();
        t_zero_dst();
        t_busy_start();
        t_irq_resume(16, 3, "copy");
        t_irq_resume(3, 6, "pad");
        t_irq_read();
        t_collide();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule